// File: doc/BRIEF.md
# Reference-Counted Clock-Gate Override

This block holds a pair of idle-clock-gating disable bits high for as long as any client still needs the clocks running. One bit serves a memory-management unit and the other a bus interface. Clients send single-cycle acquire pulses when they need the clocks held on and release pulses when they are done. An internal saturating reference count tracks the clients that are still active. Both disable bits rise together when the count leaves zero and fall together when the last release returns it to zero.

The two bits are also merged into a wider clock-gate control word. Every other bit of that word passes through unchanged from the incoming word. An unbalanced release does not wrap the count. Neither does an acquire past the count ceiling. Each of these sets a sticky error flag, and a dedicated clear input resets the flags.

Top module: `gate_ovr_refcnt`

## Requirements
- R1: After reset the count is 0, both disable bits are 0, and both error flags are 0.
- R2: A cycle with acquire high and release low increments the count by one on the next clock edge. If the count was 0, both disable bits become 1 on that same edge.
- R3: A cycle with release high and acquire low decrements a nonzero count by one on the next clock edge. If the count was 1, both disable bits become 0 on that edge.
- R4: The disable bits change only on a count transition from 0 to 1 or from 1 to 0. At every other time, both bits equal (count != 0).
- R5: A lone release while the count is 0 leaves the count at 0 and sets the sticky underflow flag on the next edge.
- R6: A lone acquire while the count is at its maximum (255 for the default 8-bit count) leaves the count at 255 and sets the sticky overflow flag on the next edge.
- R7: When acquire and release are high in the same cycle, the count and both disable bits do not change.
- R8: The error-clear input clears both sticky flags on the next edge. If a new error occurs in the same cycle as a clear, the new error wins and its flag is set. When no clear is given, a flag stays set.
- R9: ctrl_o equals ctrl_i, except that bit 3 (the memory-management disable, default MMU_POS) and bit 4 (the bus-interface disable, default BUS_POS) are replaced by the current disable state. This is combinational in ctrl_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acquire_i | input | 1 | Client acquire pulse |
| release_i | input | 1 | Client release pulse |
| err_clr_i | input | 1 | Clear both sticky error flags |
| ctrl_i | input | CTRL_W | Clock-gate control word from other sources |
| ctrl_o | output | CTRL_W | Control word with the two disable bits merged in |
| mmu_gate_dis_o | output | 1 | Memory-management unit idle-gate disable |
| bus_gate_dis_o | output | 1 | Bus interface idle-gate disable |
| count_o | output | CNT_W | Current reference count |
| underflow_o | output | 1 | Sticky unbalanced-release flag |
| overflow_o | output | 1 | Sticky acquire-at-ceiling flag |

## Verification
A wrong count shows up on count_o on the first edge after the faulty update. It can stay invisible on the disable bits until the count should pass through zero. At that point the bits either drop while clients remain or stay high after the last release. For this reason the bench compares count_o and both bits with a model after every cycle, over long random acquire-biased and release-biased stretches. The saturation corners are hit directly: a release at zero and an acquire at 255, with the sticky flags checked over the cycles after each.

// File: rtl/gate_ovr_pkg.sv
package gate_ovr_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_INC = 2'd1,
    OP_DEC = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/gate_ovr_cnt.sv
module gate_ovr_cnt
  import gate_ovr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dis_o,
  output logic             unf_evt_o,
  output logic             ovf_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dis_q, dis_d;

  always_comb begin
    cnt_d     = cnt_q;
    dis_d     = dis_q;
    unf_evt_o = 1'b0;
    ovf_evt_o = 1'b0;
    unique case (op_i)
      OP_INC: begin
        if (cnt_q == CNT_MAX) ovf_evt_o = 1'b1;
        else begin
          cnt_d = cnt_q + CNT_ONE;
          if (cnt_q == '0) dis_d = 1'b1;
        end
      end
      OP_DEC: begin
        if (cnt_q == '0) unf_evt_o = 1'b1;
        else begin
          cnt_d = cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) dis_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dis_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dis_q <= dis_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dis_o = dis_q;

  p_set_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC && cnt_q == '0) |=> (dis_q && cnt_q == CNT_ONE));
  p_clear_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DEC && cnt_q == CNT_ONE) |=> (!dis_q && cnt_q == '0));
  p_dis_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > CNT_ONE) |=> $stable(dis_q));
  p_unf_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DEC && cnt_q == '0) |=> (cnt_q == '0 && !dis_q));
  p_ovf_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  p_nop_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NOP) |=> ($stable(cnt_q) && $stable(dis_q)));
endmodule

// File: rtl/gate_ovr_flags.sv
module gate_ovr_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic unf_evt_i,
  input  logic ovf_evt_i,
  output logic unf_o,
  output logic ovf_o
);
  logic unf_q, ovf_q;

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      unf_q <= unf_evt_i | (unf_q & ~clr_i);
      ovf_q <= ovf_evt_i | (ovf_q & ~clr_i);
    end
  end

  assign unf_o = unf_q;
  assign ovf_o = ovf_q;

  p_unf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_q && !clr_i) |=> unf_q);
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !unf_evt_i && !ovf_evt_i) |=> (!unf_q && !ovf_q));
endmodule

// File: rtl/gate_ovr_merge.sv
module gate_ovr_merge #(
  parameter int CTRL_W  = 8,
  parameter int MMU_POS = 3,
  parameter int BUS_POS = 4
) (
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              dis_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    if (b == MMU_POS || b == BUS_POS) begin : g_ovr
      assign ctrl_o[b] = dis_i;
    end else begin : g_pass
      assign ctrl_o[b] = ctrl_i[b];
    end
  end

  always_comb begin
    if (rst_ni) begin
      a_rmw_keep_r9: assert ((ctrl_o[MMU_POS] == ctrl_o[BUS_POS]) &&
        (((ctrl_o ^ ctrl_i) & ~((CTRL_W'(1) << MMU_POS) | (CTRL_W'(1) << BUS_POS))) == '0));
    end
  end
endmodule

// File: rtl/gate_ovr_refcnt.sv
module gate_ovr_refcnt
  import gate_ovr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CTRL_W  = 8,
  parameter int MMU_POS = 3,
  parameter int BUS_POS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acquire_i,
  input  logic              release_i,
  input  logic              err_clr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              mmu_gate_dis_o,
  output logic              bus_gate_dis_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  cnt_op_e op;
  logic    dis, unf_evt, ovf_evt;

  always_comb begin
    unique case ({acquire_i, release_i})
      2'b10:   op = OP_INC;
      2'b01:   op = OP_DEC;
      default: op = OP_NOP;
    endcase
  end

  gate_ovr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .op_i(op), .cnt_o(count_o), .dis_o(dis),
    .unf_evt_o(unf_evt), .ovf_evt_o(ovf_evt)
  );

  gate_ovr_flags u_flags (
    .clk_i, .rst_ni, .clr_i(err_clr_i), .unf_evt_i(unf_evt), .ovf_evt_i(ovf_evt),
    .unf_o(underflow_o), .ovf_o(overflow_o)
  );

  gate_ovr_merge #(.CTRL_W(CTRL_W), .MMU_POS(MMU_POS), .BUS_POS(BUS_POS)) u_merge (
    .rst_ni, .ctrl_i, .dis_i(dis), .ctrl_o
  );

  assign mmu_gate_dis_o = dis;
  assign bus_gate_dis_o = dis;

  p_dis_tracks_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmu_gate_dis_o == (count_o != '0)) && (bus_gate_dis_o == mmu_gate_dis_o));
endmodule

// File: tb/gate_ovr_refcnt_bench.sv
`timescale 1ns/1ps
module gate_ovr_refcnt_bench;
  localparam int CNT_W = 8, CTRL_W = 8, MMU_POS = 3, BUS_POS = 4;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic acq = 0, rel = 0, clr = 0;
  logic [CTRL_W-1:0] ctrl_i = '0, ctrl_o;
  logic mmu_dis, bus_dis, unf, ovf;
  logic [CNT_W-1:0] cnt;

  int checks = 0, errors = 0;
  int m_cnt = 0;
  bit m_unf = 0, m_ovf = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gate_ovr_refcnt #(.CNT_W(CNT_W), .CTRL_W(CTRL_W), .MMU_POS(MMU_POS), .BUS_POS(BUS_POS))
  u_gate_ovr_refcnt (
    .clk_i(clk), .rst_ni, .acquire_i(acq), .release_i(rel), .err_clr_i(clr),
    .ctrl_i, .ctrl_o, .mmu_gate_dis_o(mmu_dis), .bus_gate_dis_o(bus_dis),
    .count_o(cnt), .underflow_o(unf), .overflow_o(ovf)
  );

  function automatic logic [CTRL_W-1:0] exp_ctrl(logic [CTRL_W-1:0] w, bit d);
    logic [CTRL_W-1:0] r = w;
    r[MMU_POS] = d;
    r[BUS_POS] = d;
    return r;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    bit d = (m_cnt != 0);
    chk({req, "/R2 R3 count"}, cnt, m_cnt);
    chk({req, "/R4 mmu"}, mmu_dis, d);
    chk({req, "/R4 bus"}, bus_dis, d);
    chk({req, "/R5 unf"}, unf, m_unf);
    chk({req, "/R6 ovf"}, ovf, m_ovf);
    chk({req, "/R9 ctrl"}, ctrl_o, exp_ctrl(ctrl_i, d));
  endtask

  // called at negedge: outputs reflect model, then apply inputs and advance model
  task automatic step(bit a, bit r, bit c, string req);
    bit ue = 0, oe = 0;
    check_all(req);
    acq = a; rel = r; clr = c;
    ctrl_i = CTRL_W'($urandom);
    #0;
    chk("R9 comb", ctrl_o, exp_ctrl(ctrl_i, m_cnt != 0));
    if (a && !r) begin
      if (m_cnt == CMAX) oe = 1; else m_cnt++;
    end else if (r && !a) begin
      if (m_cnt == 0) ue = 1; else m_cnt--;
    end
    m_unf = ue | (m_unf & !c);
    m_ovf = oe | (m_ovf & !c);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");
    // R5 underflow at zero, then sticky
    step(0, 1, 0, "R5 rel at zero");
    step(0, 0, 0, "R5 sticky");
    step(0, 0, 0, "R8 sticky hold");
    step(0, 0, 1, "R8 clear");
    // R2 first acquire, R7 simultaneous
    step(1, 0, 0, "R2 first acq");
    step(1, 1, 0, "R7 both");
    step(1, 0, 0, "R2 second acq");
    step(0, 1, 0, "R4 1->... rel");
    step(0, 1, 0, "R3 last rel");
    step(1, 1, 0, "R7 both at zero");
    // R8 new error beats clear
    step(0, 1, 1, "R8 err vs clr");
    step(0, 0, 1, "R8 clear2");
    // R6 drive to ceiling
    for (int i = 0; i < CMAX; i++) step(1, 0, 0, "R6 fill");
    step(1, 0, 0, "R6 acq at max");
    step(1, 1, 0, "R7 both at max");
    step(0, 0, 0, "R6 sticky");
    step(0, 0, 1, "R8 clear ovf");
    for (int i = 0; i < CMAX; i++) step(0, 1, 0, "R3 drain");
    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int bias = (ph % 2) ? 70 : 30;
      for (int k = 0; k < 400; k++) begin
        bit a = ($urandom % 100) < bias;
        bit r = ($urandom % 100) < (100 - bias);
        bit c = ($urandom % 50) == 0;
        step(a, r, c, "R4 random");
      end
    end
    check_all("R4 final");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule